// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the destination address of a control-transfer instruction in a processor with a 24-bit byte address space. It has two ways of doing this. In relative mode, a signed displacement of 8 or 16 bits is added to the address of the instruction that follows the branch. In indirect mode, an unsigned 8-bit pointer selects a location in the lowest 256 bytes of memory, and the block reads the branch address from that location.

A command is presented on a valid/ready pair. `cmd_ready` is high only while the block is idle. A command is taken on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. While a command is in flight, `cmd_ready` stays low, and that is the only back-pressure on the command side.

Indirect reads use a request/valid port with a 16-bit big-endian data path. The block raises `mem_req` with `mem_addr` and holds both steady until `mem_valid` is seen. In the narrow addressing mode a single word is read. In the wide addressing mode two words are read, at the pointer and then at the pointer plus 2, and the top byte of the first word is dropped.

The result appears on `target` together with a one-cycle `done` pulse and an odd-address flag. The result side has no back-pressure.

Top module: `branch_target_gen`

## Requirements
- R1: With `cmd_indirect`=0 and `cmd_long_disp`=0, the result is `cmd_pc` plus the sign extension of `cmd_disp[7:0]`.
- R2: With `cmd_indirect`=0 and `cmd_long_disp`=1, the result is `cmd_pc` plus the sign extension of `cmd_disp[15:0]`.
- R3: Relative sums are kept modulo 2^24. A carry or borrow out of bit 23 is discarded.
- R4: `cmd_ready` is 1 while the block is idle. A relative command gives `done`=1 with its result in the cycle right after the edge that accepts it, and the block is ready again in that cycle.
- R5: In indirect mode the first read address is `cmd_disp[7:0]` zero-extended to 24 bits. `cmd_disp[15:8]` has no effect.
- R6: In indirect mode with `cmd_adv`=0, exactly one word is read, and the result is that word zero-extended to 24 bits.
- R7: In indirect mode with `cmd_adv`=1, two words are read, at pointer and then at pointer+2. The result is {first word bits [7:0], second word}.
- R8: Once raised, `mem_req` and `mem_addr` stay stable until `mem_valid` is sampled high. A `mem_valid` that arrives while no request is pending has no effect.
- R9: In indirect mode, `done` rises in the cycle after the edge at which the last read word is sampled.
- R10: Whenever `done` is 1, `target_odd` equals bit 0 of `target`.
- R11: While an indirect command is in flight, `cmd_ready` is 0. Any `cmd_valid` presented then is ignored and does not change the result.
- R12: After reset, `done`=0, `mem_req`=0, `cmd_ready`=1 and `target`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block is idle and will take a command |
| cmd_indirect | input | 1 | 1 = indirect fetch, 0 = relative add |
| cmd_long_disp | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| cmd_adv | input | 1 | 1 = wide (24-bit) addressing, 0 = narrow (16-bit) |
| cmd_pc | input | 24 | Address of the next instruction |
| cmd_disp | input | 16 | Displacement, or pointer in bits [7:0] |
| mem_req | output | 1 | Read request pending |
| mem_addr | output | 24 | Read byte address |
| mem_valid | input | 1 | Read data present this cycle |
| mem_rdata | input | 16 | Read word, big-endian |
| done | output | 1 | One-cycle result strobe |
| target | output | 24 | Branch destination |
| target_odd | output | 1 | Destination is odd, and so not a legal target |

## Verification
A wrong fetch state shows up on the memory port at once. It appears as a missing second read, a second address other than pointer+2, or a request that drops before data arrives. A wrong high-byte latch only shows in `target` at the following `done`. Latency faults move `done` by a cycle relative to the last `mem_valid` or the accepting edge, so the bench pins `done` to an exact cycle. A sign-extension or masking fault corrupts only the results near the displacement extremes and the address wrap, so those cases are driven on purpose.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HIGH = 2'd1,
    FS_LOW  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/bta_rel_adder.sv
module bta_rel_adder #(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LONG_W-1:0] disp,
  input  logic              long_sel,
  output logic [ADDR_W-1:0] sum
);
  localparam int PAD_S = ADDR_W - SHORT_W;
  localparam int PAD_L = ADDR_W - LONG_W;

  logic [ADDR_W-1:0] ext_short;
  logic [ADDR_W-1:0] ext_long;
  logic [ADDR_W-1:0] offset;

  // sign extension of each displacement width
  assign ext_short = {{PAD_S{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign ext_long  = {{PAD_L{disp[LONG_W-1]}}, disp};
  assign offset    = long_sel ? ext_long : ext_short;
  // sum truncated to ADDR_W bits: wrap modulo 2^ADDR_W
  assign sum       = pc + offset;
endmodule

// File: rtl/bta_ind_fetch.sv
module bta_ind_fetch
  import bta_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [PTR_W-1:0]  ptr,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              last_hit,
  output logic [ADDR_W-1:0] last_target
);
  localparam int                HI_W = ADDR_W - WORD_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  fetch_state_e      st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              adv_q, adv_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    hi_d   = hi_q;
    adv_d  = adv_q;
    unique case (st_q)
      FS_IDLE: begin
        if (start) begin
          addr_d = ADDR_W'(ptr);
          adv_d  = adv;
          hi_d   = '0;
          st_d   = adv ? FS_HIGH : FS_LOW;
        end
      end
      FS_HIGH: begin
        if (mem_valid) begin
          // top byte of the first word is dropped
          hi_d   = mem_rdata[HI_W-1:0];
          addr_d = addr_q + STEP;
          st_d   = FS_LOW;
        end
      end
      FS_LOW: begin
        if (mem_valid) st_d = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      hi_q   <= '0;
      adv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      hi_q   <= hi_d;
      adv_q  <= adv_d;
    end
  end

  assign busy        = (st_q != FS_IDLE);
  assign mem_req     = busy;
  assign mem_addr    = addr_q;
  assign last_hit    = (st_q == FS_LOW) && mem_valid;
  assign last_target = adv_q ? {hi_q, mem_rdata} : {{HI_W{1'b0}}, mem_rdata};

  // request and address are held until data arrives
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // first read lies inside the pointer window
  assert_ptr_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mem_req && mem_addr[ADDR_W-1:PTR_W] == '0));

  // the second wide-mode read follows the first by one word
  assert_second_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_HIGH && mem_valid) |=> (mem_req && mem_addr == $past(mem_addr) + STEP));
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int ADDR_W  = 24,
  parameter int WORD_W  = 16,
  parameter int PTR_W   = 8,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_indirect,
  input  logic              cmd_long_disp,
  input  logic              cmd_adv,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [WORD_W-1:0] cmd_disp,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] target,
  output logic              target_odd
);
  logic              accept;
  logic              fetch_busy;
  logic              fetch_last;
  logic [ADDR_W-1:0] fetch_target;
  logic [ADDR_W-1:0] rel_sum;
  logic              done_q, odd_q;
  logic [ADDR_W-1:0] target_q;

  assign cmd_ready = !fetch_busy;
  assign accept    = cmd_valid && cmd_ready;

  bta_rel_adder #(
    .ADDR_W (ADDR_W),
    .SHORT_W(SHORT_W),
    .LONG_W (WORD_W)
  ) rel_i (
    .pc      (cmd_pc),
    .disp    (cmd_disp),
    .long_sel(cmd_long_disp),
    .sum     (rel_sum)
  );

  bta_ind_fetch #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .PTR_W (PTR_W)
  ) fetch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && cmd_indirect),
    .adv        (cmd_adv),
    .ptr        (cmd_disp[PTR_W-1:0]),
    .busy       (fetch_busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .last_hit   (fetch_last),
    .last_target(fetch_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      odd_q    <= 1'b0;
      target_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept && !cmd_indirect) begin
        target_q <= rel_sum;
        odd_q    <= rel_sum[0];
        done_q   <= 1'b1;
      end else if (fetch_last) begin
        target_q <= fetch_target;
        odd_q    <= fetch_target[0];
        done_q   <= 1'b1;
      end
    end
  end

  assign done       = done_q;
  assign target     = target_q;
  assign target_odd = odd_q;

  assert_rel_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_indirect) |=> (done && cmd_ready));

  assert_odd_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (target_odd == target[0]));

  assert_ind_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> done);

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> !cmd_ready);
endmodule

// File: tb/branch_target_gen_tb_top.sv
module branch_target_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic        cmd_indirect = 1'b0, cmd_long_disp = 1'b0, cmd_adv = 1'b0;
  logic [23:0] cmd_pc = '0;
  logic [15:0] cmd_disp = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done, target_odd;
  logic [23:0] target;

  int n_chk = 0, n_bad = 0, cyc = 0, last_valid_cyc = 0, n_logged = 0;
  logic [23:0] logged [0:3];
  bit spurious_en = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  branch_target_gen dut_i (.*);

  function automatic logic [15:0] mw(logic [23:0] a);
    logic [31:0] t;
    t = ({8'h00, a} * 32'h0000_9E37) ^ 32'h005A_5A5A;
    return t[23:8];
  endfunction

  function automatic logic [23:0] exp_rel(logic [23:0] pc, logic [15:0] d, bit lng);
    logic [23:0] off;
    off = lng ? {{8{d[15]}}, d} : {{16{d[7]}}, d[7:0]};
    return pc + off;
  endfunction

  function automatic logic [23:0] exp_ind(bit adv, logic [7:0] p);
    logic [15:0] w0, w1;
    w0 = mw({16'h0, p});
    w1 = mw({16'h0, p} + 24'd2);
    return adv ? {w0[7:0], w1} : {8'h00, w0};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // memory responder, drives at the falling edge
  initial begin
    int wait_ctr = 0;
    bit was_valid = 1'b0;
    bit prev_req = 1'b0;
    logic [23:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      if (prev_req && mem_req && !was_valid)
        chk(mem_addr == prev_addr, "R8 addr stable", mem_addr, prev_addr);
      prev_req  = mem_req;
      prev_addr = mem_addr;
      mem_valid = 1'b0;
      if (mem_req && !was_valid) begin
        if (wait_ctr == 0) begin
          mem_valid = 1'b1;
          mem_rdata = mw(mem_addr);
          if (n_logged < 4) logged[n_logged] = mem_addr;
          n_logged++;
          last_valid_cyc = cyc;
          wait_ctr = $urandom_range(0, 3);
        end else begin
          wait_ctr--;
        end
      end else if (!mem_req && spurious_en && $urandom_range(0, 3) == 0) begin
        mem_valid = 1'b1;
        mem_rdata = 16'(($urandom));
      end
      was_valid = mem_valid;
    end
  end

  task automatic do_cmd(bit ind, bit lng, bit adv, logic [23:0] pc, logic [15:0] d, bit junk);
    logic [23:0] exp;
    bit seen;
    exp = ind ? exp_ind(adv, d[7:0]) : exp_rel(pc, d, lng);
    @(negedge clk);
    n_logged = 0;
    chk(cmd_ready == 1'b1, "R4 ready idle", cmd_ready, 1);
    cmd_indirect = ind; cmd_long_disp = lng; cmd_adv = adv;
    cmd_pc = pc; cmd_disp = d; cmd_valid = 1'b1;
    @(negedge clk);
    if (!ind) begin
      cmd_valid = 1'b0;
      chk(done == 1'b1, "R4 rel latency", done, 1);
      chk(target == exp, lng ? "R2 rel long" : "R1 rel short", target, exp);
      chk(target_odd == exp[0], "R10 odd flag", target_odd, exp[0]);
      chk(cmd_ready == 1'b1, "R4 ready after rel", cmd_ready, 1);
    end else begin
      if (junk) begin
        cmd_indirect = 1'b0; cmd_pc = 24'(($urandom)); cmd_disp = 16'(($urandom));
        cmd_adv = ~adv;
      end else begin
        cmd_valid = 1'b0;
      end
      seen = 1'b0;
      for (int i = 0; i < 60; i++) begin
        if (done) begin seen = 1'b1; break; end
        chk(cmd_ready == 1'b0, "R11 busy", cmd_ready, 0);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(seen, "R9 done seen", seen, 1);
      chk(cyc == last_valid_cyc + 1, "R9 done timing", cyc, last_valid_cyc + 1);
      chk(target == exp, adv ? "R7 wide result" : "R6 narrow result", target, exp);
      chk(target_odd == exp[0], "R10 odd flag", target_odd, exp[0]);
      chk(n_logged == (adv ? 2 : 1), adv ? "R7 read count" : "R6 read count", n_logged, adv ? 2 : 1);
      chk(logged[0] == {16'h0, d[7:0]}, "R5 pointer addr", logged[0], {16'h0, d[7:0]});
      if (adv)
        chk(logged[1] == {16'h0, d[7:0]} + 24'd2, "R7 second addr", logged[1], {16'h0, d[7:0]} + 24'd2);
      @(negedge clk);
      chk(done == 1'b0, "R9 done pulse", done, 0);
      chk(target == exp, "R11 result kept", target, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R12 reset done", done, 0);
    chk(mem_req == 1'b0, "R12 reset req", mem_req, 0);
    chk(cmd_ready == 1'b1, "R12 reset ready", cmd_ready, 1);
    chk(target == 24'h0, "R12 reset target", target, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corner cases
    do_cmd(0, 0, 0, 24'h001000, 16'h0080, 0);   // R1 -128
    do_cmd(0, 0, 0, 24'h001000, 16'hFF7F, 0);   // R1 +127, high byte unused
    do_cmd(0, 1, 0, 24'h123456, 16'h8000, 0);   // R2 -32768
    do_cmd(0, 1, 0, 24'h123456, 16'h7FFF, 0);   // R2 +32767, odd
    do_cmd(0, 0, 0, 24'hFFFFFE, 16'h0004, 0);   // R3 wrap upward
    do_cmd(0, 1, 0, 24'h000001, 16'hFFFC, 0);   // R3 wrap downward
    do_cmd(1, 0, 0, 24'h0, 16'hAB00, 0);        // R5 pointer 0, junk high byte
    do_cmd(1, 0, 1, 24'h0, 16'h12FF, 0);        // R7 pointer 0xFF, second read 0x101
    do_cmd(1, 0, 1, 24'h0, 16'h0040, 1);        // R11 command while busy
    spurious_en = 1'b1;                         // R8 stray mem_valid while idle
    do_cmd(1, 0, 0, 24'h0, 16'h0033, 0);
    do_cmd(0, 0, 0, 24'h000200, 16'h0001, 0);

    for (int k = 0; k < 300; k++) begin
      do_cmd(1'($urandom), 1'($urandom), 1'($urandom), 24'(($urandom)),
             16'(($urandom)), 1'($urandom));
    end
    spurious_en = 1'b0;
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule